// File: doc/BRIEF.md
# Interrupt Moderation Delay Controller

This block sits between a network controller's interrupt cause logic and its single interrupt line. Every cycle it forms the pending vector as the bitwise AND of the interrupt mask and the interrupt cause. When that vector goes from empty to non-empty, the line is raised at once and a moderation window is armed. Any further assertion that would start inside the window is held back. When the window ends, the pending vector is evaluated again. The line is then raised only if something is still pending, and that new assertion arms a fresh window.

The window length comes from up to three candidates. The first is the throttle delay, which is always a candidate and counts in 256 ns units. The second is the receive absolute delay, which counts in 1024 ns units. It is a candidate only when the receive timer enable register is nonzero and the receive timer cause is pending. The third is the transmit absolute delay, which also counts in 1024 ns units. It is a candidate only when a transmit descriptor carrying the delay-enable hint was accepted since the last window decision and a transmit cause (queue empty or descriptor written) is pending. The window is the smallest nonzero candidate, counted in 256 ns ticks. A tick prescaler derives those ticks from the system clock, and a countdown timer measures the window.

Top module: `irq_moderator`

## Requirements
- R1: After reset, irq_o is 0 and no window is running, so the first pending assertion is passed through without delay.
- R2: A write through reg_we_i keeps only bits 15:0 of reg_wdata_i. The register is picked by reg_sel_i: 0 is the receive timer enable, 1 is the receive absolute delay, 2 is the transmit absolute delay and 3 is the throttle delay.
- R3: If the pending vector (irq_mask_i AND irq_cause_i) becomes nonzero while irq_o is low and no window runs, irq_o goes high on the next clock edge.
- R4: After a window of W ticks is armed at clock edge E, with a tick lasting PRESCALE clocks, a later assertion is held low through edge E+W*PRESCALE. It appears at edge E+W*PRESCALE+1 if the pending vector is still nonzero.
- R5: The transmit delay, times 4, is a candidate only if a descriptor with txd_ide_i set was accepted (txd_accept_i high) since the last window decision and cause bit 0 or bit 1 is pending.
- R6: The receive delay, times 4, is a candidate only if the receive timer enable register is nonzero and cause bit 7 is pending. The enable register's value adds no delay of its own.
- R7: The window is the minimum over the enabled nonzero candidates, and the throttle delay is always a candidate.
- R8: If every enabled candidate is zero, no window is armed, and the next assertion passes on the next edge.
- R9: When the pending vector becomes zero, irq_o falls on the next clock edge, whether or not a window is running.
- R10: With mod_en_i low, no window is ever armed, so every assertion passes on the next edge.
- R11: If a window expires with nothing pending, irq_o stays low, and the next assertion passes on the next edge and arms a new window.
- R12: A cause bit whose mask bit is 0 never drives irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_en_i | input | 1 | Global moderation enable |
| reg_we_i | input | 1 | Delay register write strobe |
| reg_sel_i | input | 2 | Delay register select |
| reg_wdata_i | input | 32 | Write data; only bits 15:0 are kept |
| irq_mask_i | input | 16 | Interrupt mask |
| irq_cause_i | input | 16 | Interrupt cause |
| txd_accept_i | input | 1 | A transmit descriptor is accepted this cycle |
| txd_ide_i | input | 1 | The accepted descriptor carries the delay-enable hint |
| irq_o | output | 1 | Moderated interrupt line |

## Verification
The bench drives inputs on falling edges and reads irq_o on the following falling edge. That read observes the single register edge which carries both an undelayed assertion and any fall of the line. For a deferred assertion, the bench records the cycle count of the edge that armed the window. It then confirms that irq_o is still low at W*PRESCALE cycles after that edge and high one cycle later. It also confirms that irq_o never rose in between, so each candidate's unit and gating is pinned to an exact cycle. Register writes become visible on the edge after the write, and every test performs its writes before it raises a cause.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  localparam int unsigned DLY_W = 16;

  typedef enum logic [1:0] {
    SEL_RX_TMR   = 2'd0,
    SEL_RX_ABS   = 2'd1,
    SEL_TX_ABS   = 2'd2,
    SEL_THROTTLE = 2'd3
  } dly_sel_e;

  typedef struct packed {
    logic [DLY_W-1:0] rx_tmr;
    logic [DLY_W-1:0] rx_abs;
    logic [DLY_W-1:0] tx_abs;
    logic [DLY_W-1:0] throttle;
  } dly_regs_t;
endpackage

// File: rtl/irq_mod_regs.sv
module irq_mod_regs
  import irq_mod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [DLY_W-1:0] wdata_i,
  output dly_regs_t        regs_o
);
  dly_regs_t regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i) begin
      case (dly_sel_e'(sel_i))
        SEL_RX_TMR:   regs_q.rx_tmr   <= wdata_i;
        SEL_RX_ABS:   regs_q.rx_abs   <= wdata_i;
        SEL_TX_ABS:   regs_q.tx_abs   <= wdata_i;
        default:      regs_q.throttle <= wdata_i;
      endcase
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/irq_mod_tick.sv
module irq_mod_tick #(
  parameter int unsigned PRESCALE = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // single-cycle strobe unless restarted
  a_r4_tick_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clear_i) |=> !tick_o);
endmodule

// File: rtl/irq_mod_window.sv
module irq_mod_window
  import irq_mod_pkg::*;
#(
  parameter int unsigned SHIFT = 2,
  localparam int unsigned WIN_W = DLY_W + SHIFT
) (
  input  dly_regs_t        regs_i,
  input  logic             tx_hint_i,
  input  logic             tx_cause_i,
  input  logic             rx_cause_i,
  output logic [WIN_W-1:0] win_o
);
  localparam int unsigned NCAND = 3;

  logic [NCAND-1:0] cand_en;
  logic [WIN_W-1:0] cand_val [NCAND];
  logic [WIN_W-1:0] cand_eff [NCAND];

  assign cand_en[0]  = tx_hint_i & tx_cause_i;
  assign cand_val[0] = WIN_W'(regs_i.tx_abs) << SHIFT;
  assign cand_en[1]  = (regs_i.rx_tmr != '0) & rx_cause_i;
  assign cand_val[1] = WIN_W'(regs_i.rx_abs) << SHIFT;
  assign cand_en[2]  = 1'b1;
  assign cand_val[2] = WIN_W'(regs_i.throttle);

  for (genvar g = 0; g < NCAND; g++) begin : g_cand
    assign cand_eff[g] = cand_en[g] ? cand_val[g] : '0;
  end

  // zero means unset and never wins
  always_comb begin
    win_o = '0;
    for (int i = 0; i < NCAND; i++) begin
      if (cand_eff[i] != '0 && (win_o == '0 || cand_eff[i] < win_o))
        win_o = cand_eff[i];
    end
  end
endmodule

// File: rtl/irq_mod_timer.sv
module irq_mod_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q <= load_i;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign run_o = run_q;

  a_r8_load_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |-> (load_i != '0));
  a_r4_run_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_mod_pkg::*;
#(
  parameter int unsigned CAUSE_W  = 16,
  parameter int unsigned WR_W     = 32,
  parameter int unsigned TXDW_BIT = 0,
  parameter int unsigned TXQE_BIT = 1,
  parameter int unsigned RXT0_BIT = 7,
  parameter int unsigned PRESCALE = 32,
  parameter int unsigned SHIFT    = 2,
  parameter int unsigned CNT_W    = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mod_en_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [WR_W-1:0]    reg_wdata_i,
  input  logic [CAUSE_W-1:0] irq_mask_i,
  input  logic [CAUSE_W-1:0] irq_cause_i,
  input  logic               txd_accept_i,
  input  logic               txd_ide_i,
  output logic               irq_o
);
  localparam int unsigned WIN_W = DLY_W + SHIFT;

  dly_regs_t          regs;
  logic [CAUSE_W-1:0] pend_vec;
  logic               pend_any, rise, decide, arm;
  logic               running, tick;
  logic               line_q, line_d, hint_q;
  logic [WIN_W-1:0]   win;
  logic               unused_wr_hi;

  assign unused_wr_hi = ^reg_wdata_i[WR_W-1:DLY_W];

  irq_mod_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i[DLY_W-1:0]),
    .regs_o  (regs)
  );

  assign pend_vec = irq_mask_i & irq_cause_i;
  assign pend_any = |pend_vec;

  irq_mod_window #(.SHIFT(SHIFT)) i_window (
    .regs_i     (regs),
    .tx_hint_i  (hint_q),
    .tx_cause_i (pend_vec[TXDW_BIT] | pend_vec[TXQE_BIT]),
    .rx_cause_i (pend_vec[RXT0_BIT]),
    .win_o      (win)
  );

  assign rise   = pend_any & ~line_q;
  assign decide = rise & ~running & mod_en_i;
  assign arm    = decide & (win != '0);

  irq_mod_tick #(.PRESCALE(PRESCALE)) i_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (arm),
    .tick_o  (tick)
  );

  irq_mod_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .load_i ({{(CNT_W-WIN_W){1'b0}}, win}),
    .tick_i (tick),
    .run_o  (running)
  );

  // new assertion inside a window is held; falls always pass
  always_comb begin
    if (rise && running) line_d = line_q;
    else                 line_d = pend_any;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      hint_q <= 1'b0;
    end else begin
      line_q <= line_d;
      if (txd_accept_i && txd_ide_i) hint_q <= 1'b1;
      else if (decide)                hint_q <= 1'b0;
    end
  end

  assign irq_o = line_q;

  a_r9_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q && !pend_any) |=> !irq_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !line_q) |=> !irq_o);
  a_r3_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_q && pend_any && !running) |=> irq_o);
  a_r10_no_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_en_i && !running) |=> !running);
endmodule

// File: tb/test_irq_moderator.sv
`timescale 1ns/1ps
module test_irq_moderator;
  localparam int P = 32;
  localparam logic [15:0] B_TXDW = 16'h0001;
  localparam logic [15:0] B_RXT0 = 16'h0080;
  localparam logic [15:0] B_MISC = 16'h0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [15:0] mask = 16'hFFFF;
  logic [15:0] cause = '0;
  logic        txd_acc = 1'b0;
  logic        txd_ide = 1'b0;
  logic        irq;

  int unsigned cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_moderator i_irq_moderator (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(mod_en),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .irq_mask_i(mask), .irq_cause_i(cause),
    .txd_accept_i(txd_acc), .txd_ide_i(txd_ide), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o=%0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic clear_regs();
    for (int i = 0; i < 4; i++) wr(2'(i), 32'h0);
  endtask

  // drop everything and let any window lapse
  task automatic settle();
    @(negedge clk);
    cause = '0; mask = 16'hFFFF;
    repeat (400) @(negedge clk);
  endtask

  task automatic accept_hint();
    @(negedge clk);
    txd_acc = 1'b1; txd_ide = 1'b1;
    @(negedge clk);
    txd_acc = 1'b0; txd_ide = 1'b0;
  endtask

  // raise, drop, raise again; second rise expected after w ticks (0: immediate)
  task automatic pulse_pair(input string req, input logic [15:0] c, input int w);
    int unsigned arm_cyc;
    logic seen;
    @(negedge clk);
    cause = c;
    @(negedge clk);
    arm_cyc = cyc;
    chk({req, " first rise"}, irq, 1'b1);
    cause = '0;
    @(negedge clk);
    chk({req, " R9 fall"}, irq, 1'b0);
    cause = c;
    if (w == 0) begin
      @(negedge clk);
      chk({req, " immediate second rise"}, irq, 1'b1);
    end else begin
      seen = 1'b0;
      while (cyc < arm_cyc + w * P) begin
        @(negedge clk);
        seen = seen | irq;
      end
      chk({req, " held through window"}, seen, 1'b0);
      @(negedge clk);
      chk({req, " released after window"}, irq, 1'b1);
    end
    settle();
  endtask

  task automatic t_reset();
    chk("R1 reset low", irq, 1'b0);
    @(negedge clk);
    cause = B_MISC;
    @(negedge clk);
    chk("R1 first assertion passes", irq, 1'b1);
    settle();
  endtask

  task automatic t_mask();
    @(negedge clk);
    mask = 16'h0000; cause = B_MISC;
    repeat (3) @(negedge clk);
    chk("R12 masked cause", irq, 1'b0);
    mask = B_MISC;
    @(negedge clk);
    chk("R3 unmask raises next edge", irq, 1'b1);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    pulse_pair("R8 zero window", B_MISC, 0);
    wr(2'd3, 32'hABCD_0003);
    pulse_pair("R2 R4 throttle 3", B_MISC, 3);
    // R11: window lapses idle, next rise is immediate
    @(negedge clk);
    cause = B_MISC;
    @(negedge clk);
    cause = '0;
    repeat (5 * P) @(negedge clk);
    chk("R11 idle expiry stays low", irq, 1'b0);
    pulse_pair("R11 rearm after idle expiry", B_MISC, 3);
    // R10
    mod_en = 1'b0;
    pulse_pair("R10 disabled", B_MISC, 0);
    mod_en = 1'b1;
    // R5
    clear_regs();
    wr(2'd2, 32'h2);
    pulse_pair("R5 no hint", B_TXDW, 0);
    accept_hint();
    pulse_pair("R5 hint tx cause", B_TXDW, 8);
    accept_hint();
    pulse_pair("R5 hint non-tx cause", B_MISC, 0);
    // R6
    clear_regs();
    wr(2'd1, 32'h1);
    pulse_pair("R6 rx enable zero", B_RXT0, 0);
    wr(2'd0, 32'h5);
    pulse_pair("R6 rx enabled", B_RXT0, 4);
    // R7
    wr(2'd3, 32'h6);
    pulse_pair("R7 min picks rx", B_RXT0, 4);
    wr(2'd3, 32'h3);
    pulse_pair("R7 min picks throttle", B_RXT0, 3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule